// File: doc/BRIEF.md
# Bipolar Single-Leg PWM Load Driver

This block turns a signed digital command for the load voltage into two logic-level drive signals for a load that is connected between a switching leg and a static direction leg. For a positive command the direction leg sits low and the switching leg carries a pulse train whose high time is proportional to the command. For a negative command the direction leg sits high and the switching leg carries the complementary pulse train, so the average load voltage reverses sign. A third output tells the external gate drivers whether to drive both legs or to release them to high impedance.

The switching period comes either from an internal ramp counter with two selectable lengths, a short one and one five times longer, or from an external synchronisation clock whose every edge starts a new period, which doubles its rate. A new direction and duty value are accepted only at a period boundary. A hysteresis band around zero keeps the block from dithering between the two zero-voltage states (both legs low, both legs high). An active-low run input releases the outputs.

Top module: `bipwm_drv`

## Requirements
- R1: With a command greater than HYST the direction output is low and the switching output is high for C = floor(|cmd| * P / 2^(CMD_W-1)) clock cycles of every period of P cycles.
- R2: With a command less than -HYST the direction output is high and the switching output is high for P - C cycles of every period, C as in R1; a small cooling command followed by a small heating command moves the high time from short to long.
- R3: A magnitude of 2^(CMD_W-1)-1 or more saturates C to P: 100 % high time when cooling, 0 % when heating.
- R4: Direction and duty change only at a period boundary, so two direction reversals in internal mode are a whole number of periods apart.
- R5: For a command in [-HYST, +HYST] the direction is kept; a command of the opposite sign inside the band gives C = 0 (both legs low when cooling, both high when heating).
- R6: With slow_i low the internal period is FAST_PER cycles; with slow_i high it is SLOW_MULT times longer.
- R7: With int_sel_i low, every edge (rising or falling) of sync_i starts a new period; without edges the ramp holds at its last count.
- R8: With run_i low, oe_o, pwm_o and dir_o are all low from the next clock cycle.
- R9: During and right after reset oe_o, pwm_o and dir_o are low; direction starts in cooling with C = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | CMD_W | Signed two's-complement load-voltage command |
| slow_i | input | 1 | Period select: 0 short period, 1 period SLOW_MULT times longer |
| int_sel_i | input | 1 | Timebase select: 1 internal ramp, 0 external sync |
| sync_i | input | 1 | External synchronisation clock, asynchronous |
| run_i | input | 1 | Active-low shutdown: 0 releases the outputs |
| pwm_o | output | 1 | Switching leg level |
| dir_o | output | 1 | Direction leg level (1 heating) |
| oe_o | output | 1 | Output drive enable (0 means high impedance) |

## Verification
The assertions take for granted that cmd_i, slow_i, int_sel_i and run_i are synchronous to clk_i, and that sync_i, although asynchronous, has edges spaced by more than the synchroniser depth, so no edge is lost. The bench changes its synchronous inputs only on the falling clock edge and toggles sync_i every twelve cycles, well above that spacing. Duty and period are measured over windows that are whole multiples of the period, which makes the counts independent of where the first boundary falls after a command change.

// File: rtl/bipwm_pkg.sv
`timescale 1ns/1ps
package bipwm_pkg;
  typedef enum logic {
    DIR_COOL = 1'b0,
    DIR_HEAT = 1'b1
  } dir_e;
endpackage

// File: rtl/bipwm_rst_sync.sv
`timescale 1ns/1ps
module bipwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/bipwm_timebase.sv
`timescale 1ns/1ps
module bipwm_timebase #(
  parameter int FAST_PER    = 20,
  parameter int SLOW_MULT   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_i,
  input  logic             int_sel_i,
  input  logic             sync_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] per_sel_o
);
  localparam logic [CNT_W-1:0] FAST_C = CNT_W'(FAST_PER);
  localparam logic [CNT_W-1:0] SLOW_C = CNT_W'(FAST_PER * SLOW_MULT);

  logic [SYNC_STAGES:0] sync_q, sync_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [CNT_W-1:0]     per_q, per_d;
  logic                 at_end, sync_edge;

  // next state
  always_comb begin
    sync_d    = {sync_q[SYNC_STAGES-1:0], sync_i};
    sync_edge = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
    at_end    = (cnt_q >= per_q - 1'b1);
    per_sel_o = slow_i ? SLOW_C : FAST_C;
    tick_o    = int_sel_i ? at_end : sync_edge;
    if (tick_o)      cnt_d = '0;
    else if (at_end) cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
    per_d = tick_o ? per_sel_o : per_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      per_q  <= FAST_C;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
endmodule

// File: rtl/bipwm_duty_map.sv
`timescale 1ns/1ps
module bipwm_duty_map
  import bipwm_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int CNT_W = 7,
  parameter int HYST  = 4
) (
  input  logic signed [CMD_W-1:0] cmd_i,
  input  dir_e                    dir_cur_i,
  input  logic [CNT_W-1:0]        per_i,
  output dir_e                    dir_nxt_o,
  output logic [CNT_W-1:0]        cmp_nxt_o
);
  localparam int                      PW     = CMD_W + CNT_W;
  localparam logic signed [CMD_W-1:0] BAND_HI = CMD_W'(HYST);
  localparam logic signed [CMD_W-1:0] BAND_LO = -BAND_HI;
  localparam logic [CMD_W-1:0]        FULL_C = CMD_W'((2 ** (CMD_W - 1)) - 1);

  logic             neg;
  logic [CMD_W:0]   ext, absx;
  logic [CMD_W-1:0] mag, eff;
  logic [PW-1:0]    prod, scaled;

  always_comb begin
    if (cmd_i > BAND_HI)      dir_nxt_o = DIR_COOL;
    else if (cmd_i < BAND_LO) dir_nxt_o = DIR_HEAT;
    else                      dir_nxt_o = dir_cur_i;

    neg  = cmd_i[CMD_W-1];
    ext  = {cmd_i[CMD_W-1], cmd_i};
    absx = neg ? (~ext + 1'b1) : ext;
    mag  = absx[CMD_W-1:0];
    eff  = ((dir_nxt_o == DIR_HEAT) == neg) ? mag : '0;

    prod   = PW'(eff) * PW'(per_i);
    scaled = prod >> (CMD_W - 1);
    if (eff >= FULL_C) cmp_nxt_o = per_i;
    else               cmp_nxt_o = scaled[CNT_W-1:0];
  end
endmodule

// File: rtl/bipwm_drv.sv
`timescale 1ns/1ps
module bipwm_drv
  import bipwm_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int FAST_PER    = 20,
  parameter int SLOW_MULT   = 5,
  parameter int HYST        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [CMD_W-1:0] cmd_i,
  input  logic                    slow_i,
  input  logic                    int_sel_i,
  input  logic                    sync_i,
  input  logic                    run_i,
  output logic                    pwm_o,
  output logic                    dir_o,
  output logic                    oe_o
);
  localparam int CNT_W = $clog2(FAST_PER * SLOW_MULT + 1);

  logic             rst_q_n;
  logic             tick;
  logic [CNT_W-1:0] cnt, per, per_sel;
  dir_e             dir_q, dir_d, dir_nxt;
  logic [CNT_W-1:0] cmp_q, cmp_d, cmp_nxt;
  logic             run_q;
  logic             pwm_raw;

  bipwm_rst_sync #(.STAGES(2)) i_rst (
    .clk_i(clk_i), .arst_ni(rst_ni), .rst_no(rst_q_n)
  );

  bipwm_timebase #(
    .FAST_PER(FAST_PER), .SLOW_MULT(SLOW_MULT),
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) i_tb (
    .clk_i(clk_i), .rst_ni(rst_q_n), .slow_i(slow_i), .int_sel_i(int_sel_i),
    .sync_i(sync_i), .tick_o(tick), .cnt_o(cnt), .per_o(per), .per_sel_o(per_sel)
  );

  bipwm_duty_map #(.CMD_W(CMD_W), .CNT_W(CNT_W), .HYST(HYST)) i_map (
    .cmd_i(cmd_i), .dir_cur_i(dir_q), .per_i(per_sel),
    .dir_nxt_o(dir_nxt), .cmp_nxt_o(cmp_nxt)
  );

  // next state: settings are only taken at a period boundary
  always_comb begin
    dir_d = tick ? dir_nxt : dir_q;
    cmp_d = tick ? cmp_nxt : cmp_q;
  end

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      dir_q <= DIR_COOL;
      cmp_q <= '0;
      run_q <= 1'b0;
    end else begin
      dir_q <= dir_d;
      cmp_q <= cmp_d;
      run_q <= run_i;
    end
  end

  always_comb begin
    if (dir_q == DIR_HEAT) pwm_raw = (cnt >= cmp_q);
    else                   pwm_raw = (cnt < cmp_q);
  end

  assign oe_o  = run_q;
  assign pwm_o = run_q & pwm_raw;
  assign dir_o = run_q & (dir_q == DIR_HEAT);
endmodule

// File: rtl/bipwm_drv_chk.sv
`timescale 1ns/1ps
module bipwm_drv_chk #(
  parameter int CMD_W = 8,
  parameter int CNT_W = 7,
  parameter int HYST  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    int_sel,
  input logic signed [CMD_W-1:0] cmd,
  input logic                    dir_q,
  input logic [CNT_W-1:0]        cmp_q,
  input logic [CNT_W-1:0]        cnt,
  input logic [CNT_W-1:0]        per,
  input logic                    run,
  input logic                    pwm_o,
  input logic                    dir_o,
  input logic                    oe_o
);
  localparam logic signed [CMD_W-1:0] B_HI = CMD_W'(HYST);
  localparam logic signed [CMD_W-1:0] B_LO = -B_HI;

  assert_cool_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmd > B_HI) |=> !dir_q);

  assert_heat_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmd < B_LO) |=> dir_q);

  assert_cmp_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q <= per);

  assert_dir_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_q) |-> $past(tick));

  assert_cmp_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_q) |-> $past(tick));

  assert_band_keeps_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmd <= B_HI && cmd >= B_LO) |=> $stable(dir_q));

  assert_ramp_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> cnt < per);

  assert_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!oe_o && !pwm_o && !dir_o));
endmodule

bind bipwm_drv bipwm_drv_chk #(.CMD_W(CMD_W), .CNT_W(CNT_W), .HYST(HYST)) i_chk (
  .clk(clk_i), .rst_n(rst_q_n), .tick(tick), .int_sel(int_sel_i), .cmd(cmd_i),
  .dir_q(dir_q), .cmp_q(cmp_q), .cnt(cnt), .per(per), .run(run_i),
  .pwm_o(pwm_o), .dir_o(dir_o), .oe_o(oe_o)
);

// File: tb/test_bipwm_drv.sv
`timescale 1ns/1ps
module test_bipwm_drv;
  localparam int CMD_W = 8;
  localparam int FP    = 20;
  localparam int SP    = 100;
  localparam int HYST  = 4;
  localparam int XH    = 12;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic signed [CMD_W-1:0] cmd;
  logic                    slow, int_sel, sync, run;
  logic                    pwm, dir, oe;
  logic                    ext_run;
  int                      n_tests = 0, n_fail = 0;
  int                      cyc = 0;
  bit                      done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bipwm_drv #(.CMD_W(CMD_W), .FAST_PER(FP), .SLOW_MULT(5), .HYST(HYST)) i_bipwm_drv (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .slow_i(slow), .int_sel_i(int_sel),
    .sync_i(sync), .run_i(run), .pwm_o(pwm), .dir_o(dir), .oe_o(oe)
  );

  initial begin
    sync = 1'b0;
    ext_run = 1'b0;
    forever begin
      repeat (XH) @(negedge clk);
      if (ext_run) sync = ~sync;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count high cycles, rising edges and direction-high cycles over n samples
  task automatic measure(input int n, output int hi, output int rises, output int dhi);
    logic prev;
    hi = 0; rises = 0; dhi = 0;
    @(negedge clk);
    prev = pwm;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm) hi++;
      if (pwm && !prev) rises++;
      if (dir) dhi++;
      prev = pwm;
    end
  endtask

  task automatic apply(input int c, input int settle);
    @(negedge clk);
    cmd = CMD_W'(c);
    repeat (settle) @(negedge clk);
  endtask

  function automatic int cval(input int m, input int p);
    if (m >= 127) return p;
    return (m * p) / 128;
  endfunction

  task automatic t_reset;
    int hi, r, d;
    rst_n = 1'b0; run = 1'b1; cmd = '0; slow = 1'b0; int_sel = 1'b1;
    repeat (5) @(negedge clk);
    check(!oe && !pwm && !dir, "R9 outputs in reset", {oe, pwm, dir}, 0);
    rst_n = 1'b1;
    repeat (3 * FP) @(negedge clk);
    measure(2 * FP, hi, r, d);
    check(hi == 0 && d == 0, "R9 zero cooling after reset", hi + d, 0);
    check(oe == 1'b1, "R9 oe after reset", oe, 1);
  endtask

  task automatic t_cool;
    int hi, r, d;
    apply(64, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(hi == 5 * cval(64, FP), "R1 cmd 64 high", hi, 5 * cval(64, FP));
    check(d == 0, "R1 dir low", d, 0);
    apply(32, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(hi == 5 * cval(32, FP), "R1 cmd 32 high", hi, 5 * cval(32, FP));
  endtask

  task automatic t_heat;
    int hi, r, d;
    apply(-32, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(hi == 5 * (FP - cval(32, FP)), "R2 cmd -32 high", hi, 5 * (FP - cval(32, FP)));
    check(d == 5 * FP, "R2 dir high", d, 5 * FP);
    apply(8, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(hi == 5 * cval(8, FP) && d == 0, "R2 small cooling before swap", hi, 5 * cval(8, FP));
    apply(-8, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(hi == 5 * (FP - cval(8, FP)) && d == 5 * FP, "R2 small heating after swap",
          hi, 5 * (FP - cval(8, FP)));
  endtask

  task automatic t_sat;
    int hi, r, d;
    apply(127, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(hi == 5 * FP, "R3 cmd 127 full", hi, 5 * FP);
    apply(126, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(hi == 5 * cval(126, FP), "R3 cmd 126 not saturated", hi, 5 * cval(126, FP));
    apply(-128, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(hi == 0 && d == 5 * FP, "R3 cmd -128 zero high", hi, 0);
  endtask

  task automatic t_hyst;
    int hi, r, d;
    apply(-40, 3 * FP);
    apply(HYST, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(d == 5 * FP && hi == 5 * FP, "R5 +band keeps heating both high", hi + d, 10 * FP);
    apply(HYST + 1, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(d == 0 && hi == 5 * cval(HYST + 1, FP), "R5 beyond band cools", d, 0);
    apply(-HYST, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(d == 0 && hi == 0, "R5 -band keeps cooling both low", hi + d, 0);
    apply(-HYST - 1, 3 * FP);
    measure(5 * FP, hi, r, d);
    check(d == 5 * FP && hi == 5 * FP, "R5 beyond band heats", d, 5 * FP);
  endtask

  task automatic t_boundary;
    int a, b, guard;
    apply(40, 3 * FP);
    repeat (7) @(negedge clk);
    cmd = -40;
    guard = 0;
    while (!dir && guard < 3 * FP) begin @(negedge clk); guard++; end
    a = cyc;
    repeat (3) @(negedge clk);
    cmd = 40;
    guard = 0;
    while (dir && guard < 3 * FP) begin @(negedge clk); guard++; end
    b = cyc;
    check(((b - a) % FP) == 0 && b > a, "R4 reversals on period grid", (b - a) % FP, 0);
  endtask

  task automatic t_slow;
    int hi, r, d;
    apply(32, 3 * FP);
    measure(2 * SP, hi, r, d);
    check(r == 2 * SP / FP, "R6 fast period pulses", r, 2 * SP / FP);
    @(negedge clk); slow = 1'b1;
    repeat (3 * SP) @(negedge clk);
    measure(2 * SP, hi, r, d);
    check(r == 2, "R6 slow period pulses", r, 2);
    check(hi == 2 * cval(32, SP), "R6 slow high count", hi, 2 * cval(32, SP));
    @(negedge clk); slow = 1'b0;
    repeat (3 * SP) @(negedge clk);
  endtask

  task automatic t_ext;
    int hi, r, d;
    apply(64, 3 * FP);
    @(negedge clk); int_sel = 1'b0; ext_run = 1'b1;
    repeat (6 * XH) @(negedge clk);
    measure(4 * XH, hi, r, d);
    check(hi == 4 * cval(64, FP), "R7 ext cooling high", hi, 4 * cval(64, FP));
    check(r == 4, "R7 ext period per edge", r, 4);
    apply(-64, 6 * XH);
    measure(4 * XH, hi, r, d);
    check(hi == 4 * (XH - cval(64, FP)), "R7 ext heating high", hi, 4 * (XH - cval(64, FP)));
    apply(64, 6 * XH);
    @(negedge clk); ext_run = 1'b0;
    repeat (3 * FP) @(negedge clk);
    measure(2 * FP, hi, r, d);
    check(hi == 0, "R7 ramp holds without edges", hi, 0);
    @(negedge clk); int_sel = 1'b1;
    repeat (3 * FP) @(negedge clk);
  endtask

  task automatic t_shutdown;
    int hi, r, d;
    apply(-32, 3 * FP);
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    check(oe == 1'b0, "R8 oe low", oe, 0);
    measure(2 * FP, hi, r, d);
    check(hi == 0 && d == 0, "R8 legs low in shutdown", hi + d, 0);
    @(negedge clk); run = 1'b1;
    repeat (3 * FP) @(negedge clk);
    measure(2 * FP, hi, r, d);
    check(oe && d == 2 * FP, "R8 resumes after run", d, 2 * FP);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cool();
    t_heat();
    t_sat();
    t_hyst();
    t_boundary();
    t_slow();
    t_ext();
    t_shutdown();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule